// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block drives an 8080-style parallel bus toward a smart display panel. The host loads 32-bit words into a small FIFO. It programs the strobe timing, the beat width, the command/data selection and the number of bus cycles, then pulses `start`. The engine lowers chip select and splits each FIFO word into 8-bit or 16-bit beats. It issues one write strobe per beat. Each strobe's active and inactive lengths are counted in bus ticks, and a bus tick is the core clock divided by 1 to 8.

In read mode the same strobe scheme runs on the read-enable line. Each captured beat is packed into a 32-bit word, least significant beat first, and the word is pushed into the same FIFO for the host to drain. The `idle` output shows when every programmed cycle has finished. Software waits for it after a write before it starts a read.

Top module: `disp_bus_engine`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_we_n` and `bus_re_n` are 1, `idle` is 1, `wr_ready` is 1 and `rd_valid` is 0.
- R2: Each strobe stays low for exactly (`cfg_tw0`+1)×(`cfg_div_m1`+1) clocks.
- R3: Between two strobes of one transfer, with the FIFO supplying data, the strobe stays high for (T+1)×(`cfg_div_m1`+1)+1 clocks. T is `cfg_tw1`, except that a `cfg_tw1` of 0 or 1 is raised to 2, so the rest phase is never shorter than 3 ticks.
- R4: With `cfg_wide`=0, each word gives 4 beats on `bus_dout[7:0]`, bits [7:0] first, and `bus_dout[15:8]` is 0. With `cfg_wide`=1, each word gives 2 beats on `bus_dout[15:0]`, bits [15:0] first.
- R5: A transfer issues exactly `cfg_len_m1`+1 strobes. `cfg_len_m1` is an 18-bit count.
- R6: `bus_dc` takes the `cfg_data` value latched at `start` (0 = command, 1 = data) and holds it through the whole transfer.
- R7: `bus_cs_n` goes low on the clock after `start` is accepted. It stays low until the last cycle's rest phase ends, then returns to 1. No strobe is ever low while chip select is high.
- R8: `idle` is 0 while a transfer runs and returns to 1 when it completes. A `start` pulse during a transfer is ignored.
- R9: With `cfg_rd`=1 the engine strobes `bus_re_n`, and `bus_we_n` stays 1. `bus_din` is captured on the clock where `bus_re_n` rises. Beats are packed least significant first (8-bit beats from `bus_din[7:0]`). A word is pushed when it is full or when the transfer ends, and a partial word is zero-filled. The words are read out through `rd_data`/`rd_valid`/`rd_ready`.
- R10: In write mode `wr_ready` is 0 once the FIFO holds `FIFO_DEPTH` words. A `wr_valid` while `wr_ready` is 0 stores nothing.
- R11: If the FIFO is empty when a new word is needed mid-transfer, the engine holds chip select low with no strobe until a word arrives. It then continues with that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer with the current configuration (taken only when idle) |
| cfg_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| cfg_data | input | 1 | 1 = data cycles, 0 = command cycles |
| cfg_wide | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats |
| cfg_div_m1 | input | 3 | Tick divider minus one |
| cfg_tw0 | input | 4 | Strobe-active length in ticks minus one |
| cfg_tw1 | input | 6 | Rest-of-cycle length in ticks minus one (minimum 2) |
| cfg_len_m1 | input | 18 | Bus cycles in the transfer minus one |
| wr_valid | input | 1 | Host offers a word to the FIFO |
| wr_data | input | 32 | Word offered by the host |
| wr_ready | output | 1 | FIFO accepts a host word (write mode, not full) |
| rd_ready | input | 1 | Host takes the word on `rd_data` |
| rd_valid | output | 1 | A read-back word is available |
| rd_data | output | 32 | Oldest FIFO word |
| idle | output | 1 | No transfer in progress |
| bus_cs_n | output | 1 | Panel chip select, active low |
| bus_dc | output | 1 | Command (0) / data (1) select |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_oe | output | 1 | Bus data driver enable during write transfers |
| bus_dout | output | 16 | Bus data driven to the panel |
| bus_din | input | 16 | Bus data returned by the panel |

## Verification
Chip select, `bus_dc` and the `idle` change all come from state registers, so each is due one clock after the edge that accepts `start` or ends the last rest phase. The bench samples them on the falling edge that follows. Strobe widths and gaps are not pinned to absolute cycles: a falling-edge monitor counts the low and high clocks of each strobe and records the beat on the bus at each falling strobe. These counts are compared with (tw0+1)×div and (tw1+1)×div+1. Read data is placed on `bus_din` on the falling edge after `bus_re_n` drops, so it is stable at the capture edge. The packed words are checked only after `idle` returns.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
    localparam int DIV_W     = 3;
    localparam int TW0_W     = 4;
    localparam int TW1_W     = 6;
    localparam int LEN_W     = 18;
    localparam int WORD_W    = 32;
    localparam int BUS_W     = 16;
    localparam int NB_W      = BUS_W / 2;
    localparam int TW1_FLOOR = 2;
    localparam int SH_W      = $clog2(WORD_W) + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ACT  = 2'd2,
        ST_REST = 2'd3
    } st_e;

    typedef struct packed {
        st_e               st;
        logic              rd;
        logic              wide;
        logic              dc;
        logic [TW0_W-1:0]  tw0;
        logic [TW1_W-1:0]  tw1;
        logic [LEN_W-1:0]  rem;
        logic [TW1_W-1:0]  cnt;
        logic [1:0]        bidx;
        logic [WORD_W-1:0] word;
    } seq_s;
endpackage

// File: rtl/dbe_tick_gen.sv
module dbe_tick_gen #(
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] div_m1,
    output logic          tick
);
    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div_m1);
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + DW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tick_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(tick)) |-> (cnt_q != '0));
endmodule

// File: rtl/dbe_fifo.sv
module dbe_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    output logic [W-1:0] qdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } ptr_s;

    ptr_s         d, q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        d     = q;
        full  = (q.cnt == (AW+1)'(DEPTH));
        empty = (q.cnt == '0);
        qdata = mem_q[q.rp];
        if (push) d.wp = (q.wp == AW'(DEPTH-1)) ? '0 : q.wp + AW'(1);
        if (pop)  d.rp = (q.rp == AW'(DEPTH-1)) ? '0 : q.rp + AW'(1);
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + (AW+1)'(1);
            2'b01:   d.cnt = q.cnt - (AW+1)'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[q.wp] <= pdata;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dbe_seq.sv
module dbe_seq
    import dbe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_rd,
    input  logic              cfg_data,
    input  logic              cfg_wide,
    input  logic [TW0_W-1:0]  cfg_tw0,
    input  logic [TW1_W-1:0]  cfg_tw1,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic [BUS_W-1:0]  bus_din,
    input  logic              tick,
    input  logic              f_empty,
    input  logic              f_full,
    input  logic [WORD_W-1:0] f_q,
    output logic              tick_en,
    output logic              f_pop,
    output logic              f_push,
    output logic [WORD_W-1:0] f_pdata,
    output logic              mode_rd,
    output logic              busy,
    output logic              cs_n,
    output logic              we_n,
    output logic              re_n,
    output logic              dc,
    output logic              oe,
    output logic [BUS_W-1:0]  dout
);
    localparam int BEATS_N = WORD_W / NB_W;
    localparam int BEATS_W = WORD_W / BUS_W;

    seq_s              d, q;
    logic [SH_W-1:0]   sh;
    logic              last_beat;
    logic [BUS_W-1:0]  beat_in;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_sh;

    always_comb begin
        d       = q;
        f_pop   = 1'b0;
        f_push  = 1'b0;
        sh      = SH_W'(q.bidx) * SH_W'(q.wide ? BUS_W : NB_W);
        last_beat = q.wide ? (q.bidx == 2'(BEATS_W - 1))
                           : (q.bidx == 2'(BEATS_N - 1));
        beat_in = q.wide ? bus_din : {{(BUS_W-NB_W){1'b0}}, bus_din[NB_W-1:0]};
        merged  = q.word | (WORD_W'(beat_in) << sh);
        word_sh = q.word >> sh;
        f_pdata = merged;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st   = ST_LOAD;
                    d.rd   = cfg_rd;
                    d.wide = cfg_wide;
                    d.dc   = cfg_data;
                    d.tw0  = cfg_tw0;
                    d.tw1  = (cfg_tw1 < TW1_W'(TW1_FLOOR)) ? TW1_W'(TW1_FLOOR) : cfg_tw1;
                    d.rem  = cfg_len_m1;
                    d.cnt  = '0;
                    d.bidx = '0;
                    d.word = '0;
                end
            end
            ST_LOAD: begin
                d.cnt = '0;
                if (q.rd) begin
                    if (!f_full) d.st = ST_ACT;
                end else if (q.bidx != '0) begin
                    d.st = ST_ACT;
                end else if (!f_empty) begin
                    f_pop  = 1'b1;
                    d.word = f_q;
                    d.st   = ST_ACT;
                end
            end
            ST_ACT: begin
                if (tick) begin
                    if (q.cnt == TW1_W'(q.tw0)) begin
                        d.st  = ST_REST;
                        d.cnt = '0;
                        if (q.rd) begin
                            d.word = merged;
                            if (last_beat || q.rem == '0) begin
                                f_push = 1'b1;
                                d.word = '0;
                            end
                        end
                    end else begin
                        d.cnt = q.cnt + TW1_W'(1);
                    end
                end
            end
            ST_REST: begin
                if (tick) begin
                    if (q.cnt == q.tw1) begin
                        d.cnt = '0;
                        if (q.rem == '0) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.rem  = q.rem - LEN_W'(1);
                            d.bidx = last_beat ? 2'd0 : q.bidx + 2'd1;
                            d.st   = ST_LOAD;
                        end
                    end else begin
                        d.cnt = q.cnt + TW1_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        tick_en = (q.st == ST_ACT) || (q.st == ST_REST);
        busy    = (q.st != ST_IDLE);
        cs_n    = (q.st == ST_IDLE);
        we_n    = !((q.st == ST_ACT) && !q.rd);
        re_n    = !((q.st == ST_ACT) && q.rd);
        dc      = q.dc;
        mode_rd = q.rd;
        oe      = busy && !q.rd;
        dout    = '0;
        if (oe) dout = q.wide ? word_sh[BUS_W-1:0]
                              : {{(BUS_W-NB_W){1'b0}}, word_sh[NB_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7
    strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !cs_n);
    // R9
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_n || re_n);
    // R6
    dc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> $stable(dc));
    // R3
    rest_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(we_n) && !cs_n) |=> we_n ##1 we_n);
endmodule

// File: rtl/disp_bus_engine.sv
module disp_bus_engine
    import dbe_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_rd,
    input  logic              cfg_data,
    input  logic              cfg_wide,
    input  logic [DIV_W-1:0]  cfg_div_m1,
    input  logic [TW0_W-1:0]  cfg_tw0,
    input  logic [TW1_W-1:0]  cfg_tw1,
    input  logic [LEN_W-1:0]  cfg_len_m1,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_ready,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_data,
    output logic              idle,
    output logic              bus_cs_n,
    output logic              bus_dc,
    output logic              bus_we_n,
    output logic              bus_re_n,
    output logic              bus_oe,
    output logic [BUS_W-1:0]  bus_dout,
    input  logic [BUS_W-1:0]  bus_din
);
    logic              tick, tick_en;
    logic              e_pop, e_push, mode_rd, busy;
    logic [WORD_W-1:0] e_pdata;
    logic              f_push, f_pop, f_full, f_empty;
    logic [WORD_W-1:0] f_pdata, f_q;
    logic [DIV_W-1:0]  div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              div_q <= '0;
        else if (start && !busy) div_q <= cfg_div_m1;
    end

    always_comb begin
        f_push   = mode_rd ? e_push  : (wr_valid && !f_full);
        f_pdata  = mode_rd ? e_pdata : wr_data;
        f_pop    = mode_rd ? (rd_ready && !f_empty) : e_pop;
        wr_ready = !mode_rd && !f_full;
        rd_valid = mode_rd && !f_empty;
        rd_data  = f_q;
        idle     = !busy;
    end

    dbe_tick_gen #(.DW(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .div_m1(div_q), .tick(tick)
    );

    dbe_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(f_push), .pdata(f_pdata), .pop(f_pop),
        .qdata(f_q), .full(f_full), .empty(f_empty)
    );

    dbe_seq i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rd(cfg_rd),
        .cfg_data(cfg_data), .cfg_wide(cfg_wide), .cfg_tw0(cfg_tw0),
        .cfg_tw1(cfg_tw1), .cfg_len_m1(cfg_len_m1), .bus_din(bus_din),
        .tick(tick), .f_empty(f_empty), .f_full(f_full), .f_q(f_q),
        .tick_en(tick_en), .f_pop(e_pop), .f_push(e_push), .f_pdata(e_pdata),
        .mode_rd(mode_rd), .busy(busy), .cs_n(bus_cs_n), .we_n(bus_we_n),
        .re_n(bus_re_n), .dc(bus_dc), .oe(bus_oe), .dout(bus_dout)
    );

    // R8
    idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> bus_cs_n);
endmodule

// File: tb/test_disp_bus_engine.sv
`timescale 1ns/1ps
module test_disp_bus_engine;
    localparam int LIMIT = 150000;

    typedef struct packed {
        logic [2:0] div;
        logic [3:0] tw0;
        logic [5:0] tw1;
        logic       wide;
        logic       dc;
        logic [7:0] len;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{3'd0, 4'd0,  6'd2,  1'b0, 1'b1, 8'd7},
        '{3'd1, 4'd3,  6'd5,  1'b1, 1'b0, 8'd3},
        '{3'd2, 4'd1,  6'd0,  1'b0, 1'b1, 8'd3},
        '{3'd7, 4'd15, 6'd1,  1'b1, 1'b1, 8'd1},
        '{3'd0, 4'd2,  6'd63, 1'b0, 1'b0, 8'd5},
        '{3'd3, 4'd0,  6'd4,  1'b1, 1'b1, 8'd2}
    };

    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic        cfg_rd = 1'b0, cfg_data = 1'b0, cfg_wide = 1'b0;
    logic [2:0]  cfg_div_m1 = '0;
    logic [3:0]  cfg_tw0 = '0;
    logic [5:0]  cfg_tw1 = '0;
    logic [17:0] cfg_len_m1 = '0;
    logic        wr_valid = 1'b0, rd_ready = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, rd_valid, idle;
    logic [31:0] rd_data;
    logic        bus_cs_n, bus_dc, bus_we_n, bus_re_n, bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = '0;

    int n_chk = 0, n_fail = 0;

    int          nb = 0, low_len = 0, high_len = 0;
    logic        prev_stb = 1'b1;
    logic [15:0] beat_v [256];
    int          low_v  [256];
    int          gap_v  [256];

    always #2 clk = ~clk;

    disp_bus_engine i_disp_bus_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rd(cfg_rd),
        .cfg_data(cfg_data), .cfg_wide(cfg_wide), .cfg_div_m1(cfg_div_m1),
        .cfg_tw0(cfg_tw0), .cfg_tw1(cfg_tw1), .cfg_len_m1(cfg_len_m1),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .idle(idle), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
        .bus_we_n(bus_we_n), .bus_re_n(bus_re_n), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .bus_din(bus_din)
    );

    // strobe monitor: widths, gaps, beats; also returns panel read data
    always @(negedge clk) begin
        logic stb;
        stb = bus_we_n & bus_re_n;
        if (!stb) begin
            if (prev_stb) begin
                if (nb > 0 && nb < 257) gap_v[nb-1] = high_len;
                if (nb < 256) beat_v[nb] = bus_dout;
                if (!bus_re_n) bus_din = 16'hA5C0 + 16'(nb);
                low_len = 1;
            end else low_len++;
        end else begin
            if (!prev_stb) begin
                if (nb < 256) low_v[nb] = low_len;
                nb++;
                high_len = 1;
            end else high_len++;
        end
        prev_stb = stb;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        $display("FAIL watchdog expired (all requirements) actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wdat(input int v, input int j);
        return 32'(32'h1122_3344 * (v + 1) + j * 32'h0102_0304);
    endfunction

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = w;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic kick(input logic [2:0] dv, input logic [3:0] t0, input logic [5:0] t1,
                        input logic wd, input logic dcv, input logic rdv, input int len);
        @(negedge clk);
        cfg_div_m1 = dv; cfg_tw0 = t0; cfg_tw1 = t1; cfg_wide = wd;
        cfg_data = dcv; cfg_rd = rdv; cfg_len_m1 = 18'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle;
        while (!idle) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n", 32'(bus_cs_n), 1);
        check("R1 we_n", 32'(bus_we_n), 1);
        check("R1 re_n", 32'(bus_re_n), 1);
        check("R1 idle", 32'(idle), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wr_ready", 32'(wr_ready), 1);
        check("R1 rd_valid", 32'(rd_valid), 0);

        // table of write vectors
        for (int v = 0; v < 6; v++) begin
            int bpw, nbe, nw, nb0, div, t1e;
            bpw = VECS[v].wide ? 2 : 4;
            nbe = int'(VECS[v].len) + 1;
            nw  = (nbe + bpw - 1) / bpw;
            div = int'(VECS[v].div) + 1;
            t1e = (VECS[v].tw1 < 2) ? 2 : int'(VECS[v].tw1);
            for (int j = 0; j < nw; j++) push_word(wdat(v, j));
            nb0 = nb;
            kick(VECS[v].div, VECS[v].tw0, VECS[v].tw1, VECS[v].wide, VECS[v].dc, 1'b0, nbe - 1);
            // R7 cs low, R6 dc latched, R8 busy
            check("R7 cs_n low in transfer", 32'(bus_cs_n), 0);
            check("R6 dc value", 32'(bus_dc), 32'(VECS[v].dc));
            check("R8 idle low while busy", 32'(idle), 0);
            wait_idle();
            check("R7 cs_n released", 32'(bus_cs_n), 1);
            check("R5 strobe count", 32'(nb - nb0), 32'(nbe));
            for (int k = 0; k < nbe; k++) begin
                logic [31:0] w, e;
                w = wdat(v, k / bpw);
                e = VECS[v].wide ? ((w >> (16 * (k % bpw))) & 32'hFFFF)
                                 : ((w >> (8 * (k % bpw))) & 32'hFF);
                check("R4 beat value", 32'(beat_v[nb0 + k]), e);
                check("R2 strobe low width", 32'(low_v[nb0 + k]), 32'((int'(VECS[v].tw0) + 1) * div));
                if (k < nbe - 1)
                    check("R3 strobe gap", 32'(gap_v[nb0 + k]), 32'((t1e + 1) * div + 1));
            end
        end

        // R8 start ignored while busy
        begin
            int nb0;
            push_word(32'hCAFE_F00D);
            nb0 = nb;
            kick(3'd1, 4'd3, 6'd5, 1'b0, 1'b1, 1'b0, 3);
            repeat (5) @(negedge clk);
            cfg_data = 1'b0; cfg_len_m1 = 18'd7; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check("R8 second start ignored dc", 32'(bus_dc), 1);
            check("R8 idle low", 32'(idle), 0);
            wait_idle();
            check("R8 strobe count unchanged", 32'(nb - nb0), 4);
            check("R8 idle back", 32'(idle), 1);
        end

        // R10 backpressure
        begin
            int nb0;
            for (int j = 0; j < 4; j++) push_word(32'h4030_2010 + 32'(j));
            check("R10 wr_ready low when full", 32'(wr_ready), 0);
            push_word(32'hDEAD_BEEF);
            nb0 = nb;
            kick(3'd0, 4'd0, 6'd2, 1'b0, 1'b1, 1'b0, 15);
            wait_idle();
            check("R10 beats from stored words", 32'(nb - nb0), 16);
            for (int k = 0; k < 16; k++)
                check("R10 beat value", 32'(beat_v[nb0 + k]),
                      ((32'h4030_2010 + 32'(k / 4)) >> (8 * (k % 4))) & 32'hFF);
            check("R10 wr_ready back", 32'(wr_ready), 1);

            // R11 stall on empty FIFO (the dropped word must not appear)
            nb0 = nb;
            kick(3'd0, 4'd0, 6'd2, 1'b0, 1'b1, 1'b0, 1);
            repeat (40) @(negedge clk);
            check("R11 no strobe while empty", 32'(nb - nb0), 0);
            check("R11 cs held low", 32'(bus_cs_n), 0);
            push_word(32'h0000_5A69);
            wait_idle();
            check("R11 resumed strobes", 32'(nb - nb0), 2);
            check("R11 beat0", 32'(beat_v[nb0]), 32'h69);
            check("R11 beat1", 32'(beat_v[nb0 + 1]), 32'h5A);
        end

        // R9 read transfer, 6 narrow beats
        begin
            int nb0;
            logic [7:0] b [6];
            nb0 = nb;
            kick(3'd0, 4'd1, 6'd2, 1'b0, 1'b1, 1'b1, 5);
            wait_idle();
            for (int k = 0; k < 6; k++) b[k] = 8'(16'hA5C0 + 16'(nb0 + k));
            check("R9 strobe count", 32'(nb - nb0), 6);
            check("R9 rd_valid", 32'(rd_valid), 1);
            check("R9 word0", rd_data, {b[3], b[2], b[1], b[0]});
            @(negedge clk); rd_ready = 1'b1;
            @(negedge clk); rd_ready = 1'b0;
            check("R9 word1 zero-filled", rd_data, {16'h0, b[5], b[4]});
            @(negedge clk); rd_ready = 1'b1;
            @(negedge clk); rd_ready = 1'b0;
            check("R9 fifo drained", 32'(rd_valid), 0);
            check("R9 we_n stayed high", 32'(bus_we_n), 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule